// File: doc/BRIEF.md
# Three-Phase Dual-Bridge Phase-Shift Gate Generator

This block drives the twelve switches of two three-phase full bridges that face each other across a transformer. A free-running tick counter sets the switching period. Every switch conducts for half of that period. Within one bridge the three legs follow one another at one third of a period. The high-side and low-side switch of a leg are driven as a complementary pair, and a programmable dead-time keeps both of them off after each change of state.

The second bridge copies the first bridge's pattern, shifted in time by a signed phase-shift request given in clock ticks. The sign of the request selects which way power flows. The request is clamped to one sixth of a period either way. The phase-shift and dead-time requests are taken into shadow registers only when a period begins, so a new value never changes a period that is already running. Dropping the enable turns every gate off. Raising it again restarts the pattern from the first tick of a fresh period.

Top module: `dab_psm`

## Requirements
- R1: The counter runs through PERIOD ticks and then repeats. The enable is first sampled high at clock edge E. The gate outputs after edge E+1+n show tick n of the period (n counted modulo PERIOD). On primary leg 0, the high gate is on for ticks dt <= t < PERIOD/2 and the low gate is on for ticks t >= PERIOD/2 + dt. Here dt is the captured dead-time.
- R2: Leg k of a bridge (k = 0, 1, 2 on bit k of the hi/lo ports) runs the leg-0 waveform late by k*PERIOD/3 ticks, taken modulo PERIOD.
- R3: Each secondary leg runs the waveform of the primary leg with the same index, late by the captured phase shift s in ticks (modulo PERIOD). A positive s makes the secondary lag. A negative s makes it lead.
- R4: A phase request above PERIOD/6 is captured as PERIOD/6. A request below -PERIOD/6 is captured as -PERIOD/6.
- R5: The high and low gate of a leg are never on together. When dt >= PERIOD/2, every gate stays off.
- R6: The phase and dead-time requests are captured only on the edge that starts a period. A change at any other time has no effect on the gates until the next period starts.
- R7: The enable is sampled low at a clock edge. All twelve gates are off after that edge. Enabling again restarts at tick 0, with the R1 timing.
- R8: The reset is synchronous and active high. After a reset edge, all gates are off and the counter is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces all gates off |
| phase_req | input | PS_W | Signed shift of the secondary bridge in ticks |
| dead_req | input | DT_W | Dead-time in ticks |
| pri_hi | output | 3 | Primary high-side gates, bit k = leg k |
| pri_lo | output | 3 | Primary low-side gates, bit k = leg k |
| sec_hi | output | 3 | Secondary high-side gates, bit k = leg k |
| sec_lo | output | 3 | Secondary low-side gates, bit k = leg k |

## Verification
The hardest cases to reach from the ports are requests that change in the middle of a period, and a stop followed by a restart that lands in the middle of a period. In both cases the outputs stay correct only if the capture point and the restart alignment are exact. The stimulus changes the phase and dead-time requests at arbitrary ticks, including saturating values on both sides. It also drops and restores the enable at an arbitrary point. A per-cycle prediction of all twelve gates is compared against the outputs. The prediction comes from the tick, the clamped shift and the captured dead-time.

// File: rtl/dab_pkg.sv
package dab_pkg;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } gate_pair_t;

    // tick offset of leg 'leg' within a period of 'period' ticks
    function automatic int leg_offset(int period, int leg);
        return (period * leg) / 3;
    endfunction

    // clamp a signed request to +/- lim
    function automatic int clamp_sym(int req, int lim);
        if (req > lim)
            return lim;
        else if (req < -lim)
            return -lim;
        else
            return req;
    endfunction

endpackage

// File: rtl/dab_period_timer.sv
module dab_period_timer
    import dab_pkg::*;
#(
    parameter int PERIOD = 4000,
    localparam int CW = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    output logic [CW-1:0] cnt,
    output logic          active,
    output logic          load
);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    tmr_state_t state;

    assign active = en && (state == TMR_RUN);
    assign load   = en && ((state == TMR_IDLE) || (cnt == LAST));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state <= TMR_IDLE;
            cnt   <= '0;
        end else if (state == TMR_IDLE) begin
            state <= TMR_RUN;
            cnt   <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/dab_shadow.sv
module dab_shadow
    import dab_pkg::*;
#(
    parameter int PERIOD = 4000,
    parameter int PS_W   = 16,
    parameter int DT_W   = 8,
    localparam int CW    = $clog2(PERIOD),
    localparam int LIM   = PERIOD / 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic signed [PS_W-1:0] phase_req,
    input  logic [DT_W-1:0]      dead_req,
    output logic signed [CW:0]   shift_sh,
    output logic [DT_W-1:0]      dt_sh
);
    int                 req_int;
    int                 sat_int;
    logic signed [CW:0] sat_val;

    always_comb begin
        req_int = int'(phase_req);
        sat_int = clamp_sym(req_int, LIM);
        sat_val = (CW+1)'(sat_int);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_sh <= '0;
            dt_sh    <= '0;
        end else if (load) begin
            shift_sh <= sat_val;
            dt_sh    <= dead_req;
        end
    end

endmodule

// File: rtl/dab_leg.sv
module dab_leg
    import dab_pkg::*;
#(
    parameter int PERIOD = 4000,
    parameter int OFFSET = 0,
    parameter int DT_W   = 8,
    localparam int CW    = $clog2(PERIOD),
    localparam int HALF  = PERIOD / 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               active,
    input  logic [CW-1:0]      cnt,
    input  logic signed [CW:0] shift,
    input  logic [DT_W-1:0]    dt,
    output gate_pair_t         gate
);
    int   pos;
    int   dti;
    logic hi_on;
    logic lo_on;

    always_comb begin
        pos = int'(cnt) - OFFSET - int'(shift);
        if (pos < 0)
            pos = pos + PERIOD;
        if (pos < 0)
            pos = pos + PERIOD;
        if (pos >= PERIOD)
            pos = pos - PERIOD;
        dti   = int'(dt);
        hi_on = (pos >= dti) && (pos < HALF);
        lo_on = (pos >= HALF + dti);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate <= '0;
        end else begin
            gate.hi <= active && hi_on;
            gate.lo <= active && lo_on;
        end
    end

endmodule

// File: rtl/dab_psm.sv
module dab_psm
    import dab_pkg::*;
#(
    parameter int PERIOD = 4000,
    parameter int PS_W   = 16,
    parameter int DT_W   = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic signed [PS_W-1:0] phase_req,
    input  logic [DT_W-1:0]        dead_req,
    output logic [2:0]             pri_hi,
    output logic [2:0]             pri_lo,
    output logic [2:0]             sec_hi,
    output logic [2:0]             sec_lo
);
    localparam int CW     = $clog2(PERIOD);
    localparam int NB     = 2;
    localparam int NLEG   = 3;

    logic [CW-1:0]      cnt;
    logic               active;
    logic               load;
    logic signed [CW:0] shift_sh;
    logic [DT_W-1:0]    dt_sh;
    gate_pair_t         gp [NB][NLEG];

    dab_period_timer #(.PERIOD(PERIOD)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .cnt    (cnt),
        .active (active),
        .load   (load)
    );

    dab_shadow #(.PERIOD(PERIOD), .PS_W(PS_W), .DT_W(DT_W)) u_shadow (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .phase_req (phase_req),
        .dead_req  (dead_req),
        .shift_sh  (shift_sh),
        .dt_sh     (dt_sh)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bridge
        logic signed [CW:0] br_shift;
        if (b == 0) begin : g_ref
            assign br_shift = '0;
        end else begin : g_follow
            assign br_shift = shift_sh;
        end
        for (genvar k = 0; k < NLEG; k++) begin : g_leg
            dab_leg #(
                .PERIOD (PERIOD),
                .OFFSET (leg_offset(PERIOD, k)),
                .DT_W   (DT_W)
            ) u_leg (
                .clk    (clk),
                .rst    (rst),
                .active (active),
                .cnt    (cnt),
                .shift  (br_shift),
                .dt     (dt_sh),
                .gate   (gp[b][k])
            );
        end
    end

    for (genvar k = 0; k < NLEG; k++) begin : g_out
        assign pri_hi[k] = gp[0][k].hi;
        assign pri_lo[k] = gp[0][k].lo;
        assign sec_hi[k] = gp[1][k].hi;
        assign sec_lo[k] = gp[1][k].lo;
    end

endmodule

// File: rtl/dab_psm_chk.sv
module dab_psm_chk #(
    parameter int PERIOD = 4000,
    parameter int DT_W   = 8,
    localparam int CW    = $clog2(PERIOD),
    localparam int LIM   = PERIOD / 6
) (
    input logic               clk,
    input logic               rst,
    input logic               en,
    input logic [2:0]         pri_hi,
    input logic [2:0]         pri_lo,
    input logic [2:0]         sec_hi,
    input logic [2:0]         sec_lo,
    input logic [CW-1:0]      cnt,
    input logic               active,
    input logic signed [CW:0] shift_sh,
    input logic [DT_W-1:0]    dt_sh
);
    // R5: no leg ever has both switches on
    a_r5_no_shoot_through: assert property (@(posedge clk) disable iff (rst)
        ((pri_hi & pri_lo) == 3'b000) && ((sec_hi & sec_lo) == 3'b000));

    // R2: 120 degree spacing of half-period blocks allows at most two high gates
    a_r2_two_high_max: assert property (@(posedge clk) disable iff (rst)
        ($countones(pri_hi) <= 2) && ($countones(sec_hi) <= 2));

    // R7: enable low at an edge leaves all gates off
    a_r7_gates_off: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> ({pri_hi, pri_lo, sec_hi, sec_lo} == 12'd0));

    // R7: a new run starts at tick 0
    a_r7_restart_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> (cnt == '0));

    // R1: counter wraps after the last tick
    a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
        (cnt == CW'(PERIOD - 1)) |=> (cnt == '0));

    // R4: captured shift is within the limit
    a_r4_shift_bound: assert property (@(posedge clk) disable iff (rst)
        (int'(shift_sh) <= LIM) && (int'(shift_sh) >= -LIM));

    // R6: shadows hold inside a running period
    a_r6_shadow_hold: assert property (@(posedge clk) disable iff (rst)
        ($past(active) && active && (cnt != '0)) |-> ($stable(shift_sh) && $stable(dt_sh)));

    // R8: gates are off right after reset
    a_r8_reset_off: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ({pri_hi, pri_lo, sec_hi, sec_lo} == 12'd0));

endmodule

bind dab_psm dab_psm_chk #(.PERIOD(PERIOD), .DT_W(DT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .pri_hi   (pri_hi),
    .pri_lo   (pri_lo),
    .sec_hi   (sec_hi),
    .sec_lo   (sec_lo),
    .cnt      (cnt),
    .active   (active),
    .shift_sh (shift_sh),
    .dt_sh    (dt_sh)
);

// File: tb/dab_psm_test.sv
`timescale 1ns/1ps
module dab_psm_test;
    localparam int P     = 120;
    localparam int PS_W  = 16;
    localparam int DT_W  = 8;
    localparam int LIM   = P / 6;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   en  = 1'b0;
    logic signed [PS_W-1:0] phase_req = '0;
    logic [DT_W-1:0]        dead_req  = '0;
    logic [2:0]             pri_hi, pri_lo, sec_hi, sec_lo;

    int    n_checks = 0;
    int    n_bad    = 0;
    string cur_req  = "R8";
    bit    done     = 1'b0;

    logic [11:0] exp_q [$];

    // bench model state
    bit m_run = 1'b0;
    int m_cnt = 0;
    int m_ps  = 0;
    int m_dt  = 0;
    bit p_rst = 1'b1;
    bit p_en  = 1'b0;
    int p_ps  = 0;
    int p_dt  = 0;

    always #2.5 clk = ~clk;

    dab_psm #(.PERIOD(P), .PS_W(PS_W), .DT_W(DT_W)) uut (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .phase_req (phase_req),
        .dead_req  (dead_req),
        .pri_hi    (pri_hi),
        .pri_lo    (pri_lo),
        .sec_hi    (sec_hi),
        .sec_lo    (sec_lo)
    );

    // bit b*6 + k*2 = high gate, +1 = low gate
    function automatic logic [11:0] pattern(int t, int s, int d);
        logic [11:0] v;
        v = '0;
        for (int b = 0; b < 2; b++) begin
            for (int k = 0; k < 3; k++) begin
                int p;
                p = t - (b == 1 ? s : 0) - (k * P) / 3;
                p = ((p % P) + P) % P;
                v[b*6 + k*2]     = (p >= d) && (p < P / 2);
                v[b*6 + k*2 + 1] = (p >= P / 2 + d);
            end
        end
        return v;
    endfunction

    function automatic int limit(int r);
        if (r > LIM) return LIM;
        if (r < -LIM) return -LIM;
        return r;
    endfunction

    function automatic logic [11:0] observed();
        logic [11:0] v;
        for (int k = 0; k < 3; k++) begin
            v[k*2]         = pri_hi[k];
            v[k*2 + 1]     = pri_lo[k];
            v[6 + k*2]     = sec_hi[k];
            v[6 + k*2 + 1] = sec_lo[k];
        end
        return v;
    endfunction

    // predictor: what the last edge should have produced
    task automatic predict();
        logic [11:0] e;
        if (p_rst) begin
            e = '0;
            m_run = 1'b0; m_cnt = 0; m_ps = 0; m_dt = 0;
        end else begin
            e = (p_en && m_run) ? pattern(m_cnt, m_ps, m_dt) : 12'd0;
            if (!p_en) begin
                m_run = 1'b0; m_cnt = 0;
            end else if (!m_run) begin
                m_run = 1'b1; m_cnt = 0; m_ps = limit(p_ps); m_dt = p_dt;
            end else if (m_cnt == P - 1) begin
                m_cnt = 0; m_ps = limit(p_ps); m_dt = p_dt;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
        exp_q.push_back(e);
    endtask

    // monitor: pop and compare away from the active edge
    always @(negedge clk) begin
        logic [11:0] e;
        logic [11:0] o;
        if (!done) begin
            predict();
            e = exp_q.pop_front();
            o = observed();
            n_checks++;
            if (o !== e) begin
                n_bad++;
                $display("FAIL %s t=%0t gates actual=%b expected=%b", cur_req, $time, o, e);
            end
            p_rst = rst; p_en = en; p_ps = int'(phase_req); p_dt = int'(dead_req);
        end
    end

    task automatic apply(string tag, bit e, int ps, int dt, int cycles);
        @(posedge clk); #1;
        cur_req   = tag;
        en        = e;
        phase_req = PS_W'(ps);
        dead_req  = DT_W'(dt);
        repeat (cycles) @(posedge clk);
    endtask

    initial begin
        // R8: reset state
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        cur_req = "R8";
        repeat (3) @(posedge clk);
        // R1, R2: basic pattern, dead-time 4, no shift
        apply("R1", 1'b1, 0, 4, 2 * P + 7);
        // R3: secondary lag
        apply("R3", 1'b1, 15, 4, 2 * P);
        // R3: secondary lead, exactly at the limit
        apply("R3", 1'b1, -LIM, 6, 2 * P);
        // R4: requests beyond both limits
        apply("R4", 1'b1, 55, 3, 2 * P);
        apply("R4", 1'b1, -300, 3, 2 * P);
        // R6: mid-period change must wait for period start
        apply("R6", 1'b1, 9, 10, 37);
        apply("R6", 1'b1, -12, 2, 2 * P);
        // R5: zero dead-time, then dead-time at and beyond half a period
        apply("R5", 1'b1, 7, 0, 2 * P);
        apply("R5", 1'b1, 7, P / 2, 2 * P);
        apply("R5", 1'b1, 7, 200, 2 * P);
        // R7: stop mid-period, then restart with new settings
        apply("R2", 1'b1, 0, 5, P + 23);
        apply("R7", 1'b0, 11, 5, 30);
        apply("R7", 1'b1, -8, 3, 2 * P + 5);
        apply("R7", 1'b0, -8, 3, 4);
        apply("R7", 1'b1, 20, 1, P + 3);
        // R8: reset while running
        @(posedge clk); #1 rst = 1'b1; cur_req = "R8";
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        repeat (P) @(posedge clk);
        @(negedge clk); #1;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        #(5 * 150000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

endmodule